// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block owns the program counter of a small 16-bit, word-addressed processor and works out the address of the next instruction every cycle. The decoder gives it a two-bit control class. The class selects one of four actions: step to the next word, test a condition and branch, branch and link, or jump to a computed target and link. For relative transfers it adds a signed 10-bit offset to the address of the following instruction. For jumps it loads the target that the register-plus-operand adder has formed.

The two link forms present the address of the following instruction as a link value. They also raise a write strobe for the destination register. When the destination is register 0, the strobe stays low and the link is dropped. The branch-and-link form then works as a plain unconditional relative branch, and the jump form works as a return or a far jump. A synchronous reset clears the PC. An advance enable freezes the PC while the rest of the processor is busy.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) loads the PC with 0x0000, and this takes priority over every other input.
- R2: While advanceEn is low, the PC keeps its value and linkWrite is low, whatever the other inputs are.
- R3: With ctrlClass = 2'b00 (sequential), each enabled edge loads PC + 1.
- R4: With ctrlClass = 2'b01 (conditional), condSel picks the test: 2'b00 is taken when Z=1, 2'b01 when Z=0, 2'b10 when C=1, 2'b11 when C=0. A taken branch loads PC + 1 + sext(offsetImm).
- R5: A conditional branch whose test fails loads PC + 1.
- R6: offsetImm is a 10-bit two's-complement value, so displacements run from +511 down to -512, counted from PC + 1.
- R7: With ctrlClass = 2'b10 (branch and link), the PC always loads PC + 1 + sext(offsetImm), whatever the flags and condSel are.
- R8: With ctrlClass = 2'b11 (jump and link), the PC loads jumpTarget.
- R9: linkValue always equals PC + 1. linkWrite is high only when ctrlClass[1] = 1, linkReg is not 0 and advanceEn is high.
- R10: With linkReg = 0, both link classes keep linkWrite low and still update the PC as in R7 and R8.
- R11: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advanceEn | input | 1 | PC update enable |
| ctrlClass | input | 2 | Control class: 00 seq, 01 cond, 10 branch-link, 11 jump-link |
| condSel | input | 2 | Condition selector for class 01 |
| offsetImm | input | 10 | Signed relative displacement |
| jumpTarget | input | 16 | Absolute target for class 11 |
| flagC | input | 1 | Carry flag |
| flagZ | input | 1 | Zero flag |
| linkReg | input | 3 | Destination register index of the link |
| pcOut | output | 16 | Current PC |
| linkValue | output | 16 | Address of the following instruction |
| linkWrite | output | 1 | Register write strobe for the link |

## Verification
The bench aims at the offset extremes +511 and -512. A design that zero-extends the offset, or counts from PC instead of PC + 1, ends up on the wrong word. It runs all four condition codes under both flag values, which catches an inverted or swapped test. It also runs branch-and-link with flags that would fail any condition, to show that branch-and-link ignores the flags. It drives linkReg = 0 and a held enable to confirm that no link write appears. It jumps to 0xFFFF and 0xFFFE to force wraparound. Fixed-seed random steps are then checked against a reference next-PC function.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [1:0] {
    CLS_SEQ   = 2'b00,
    CLS_COND  = 2'b01,
    CLS_BLINK = 2'b10,
    CLS_JLINK = 2'b11
  } pcClass_e;

  typedef enum logic [1:0] {
    TST_ZSET = 2'b00,
    TST_ZCLR = 2'b01,
    TST_CSET = 2'b10,
    TST_CCLR = 2'b11
  } condTest_e;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic takeRel;   // load PC + 1 + offset
    logic takeJump;  // load absolute target
    logic writeLink; // link goes to a real register
  } pcStrobe_t;

endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advanceEn,
  input  logic [1:0]        ctrlClass,
  input  logic [1:0]        condSel,
  input  logic              flagC,
  input  logic              flagZ,
  input  logic [REG_AW-1:0] linkReg,
  output pcStrobe_t         strobes
);

  pcClass_e  cls;
  condTest_e tst;
  logic      condMet;
  logic      isLink;
  logic      linkRegLive;

  assign cls = pcClass_e'(ctrlClass);
  assign tst = condTest_e'(condSel);

  always_comb begin
    unique case (tst)
      TST_ZSET: condMet = flagZ;
      TST_ZCLR: condMet = ~flagZ;
      TST_CSET: condMet = flagC;
      TST_CCLR: condMet = ~flagC;
      default:  condMet = 1'b0;
    endcase
  end

  assign isLink      = (cls == CLS_BLINK) || (cls == CLS_JLINK);
  assign linkRegLive = (linkReg != '0);

  always_comb begin
    strobes = '0;
    unique case (cls)
      CLS_SEQ:   strobes.takeRel = 1'b0;
      CLS_COND:  strobes.takeRel = condMet;
      CLS_BLINK: strobes.takeRel = 1'b1;
      CLS_JLINK: strobes.takeJump = 1'b1;
      default:   strobes = '0;
    endcase
    strobes.writeLink = isLink && linkRegLive && advanceEn;
  end

  a_r3_seq_no_transfer: assert property (@(posedge clk) disable iff (rst)
    (ctrlClass == 2'b00) |-> !(strobes.takeRel || strobes.takeJump));

  a_r7_blink_always: assert property (@(posedge clk) disable iff (rst)
    (ctrlClass == 2'b10) |-> strobes.takeRel);

  a_r10_r0_no_write: assert property (@(posedge clk) disable iff (rst)
    (linkReg == '0) |-> !strobes.writeLink);

  a_r2_no_write_stalled: assert property (@(posedge clk) disable iff (rst)
    !advanceEn |-> !strobes.writeLink);

  a_r4_single_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.takeRel, strobes.takeJump}));

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advanceEn,
  input  pcStrobe_t        strobes,
  input  logic [OFF_W-1:0] offsetImm,
  input  logic [PC_W-1:0]  jumpTarget,
  output logic [PC_W-1:0]  pcOut,
  output logic [PC_W-1:0]  linkValue
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] pcReg;
  logic [PC_W-1:0] seqPc;
  logic [PC_W-1:0] extOff;
  logic [PC_W-1:0] relPc;
  logic [PC_W-1:0] nextPc;

  assign seqPc  = pcReg + PC_W'(1);
  assign extOff = {{EXT_W{offsetImm[OFF_W-1]}}, offsetImm};
  assign relPc  = seqPc + extOff;

  always_comb begin
    if (strobes.takeJump)     nextPc = jumpTarget;
    else if (strobes.takeRel) nextPc = relPc;
    else                      nextPc = seqPc;
  end

  always_ff @(posedge clk) begin
    if (rst)            pcReg <= '0;
    else if (advanceEn) pcReg <= nextPc;
  end

  assign pcOut     = pcReg;
  assign linkValue = seqPc;

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (pcOut == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !advanceEn |=> $stable(pcOut));

  a_r8_jump_load: assert property (@(posedge clk) disable iff (rst)
    (advanceEn && strobes.takeJump) |=> (pcOut == $past(jumpTarget)));

  a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
    (advanceEn && !strobes.takeJump && !strobes.takeRel)
      |=> (pcOut == $past(pcOut) + PC_W'(1)));

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int OFF_W  = 10,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advanceEn,
  input  logic [1:0]        ctrlClass,
  input  logic [1:0]        condSel,
  input  logic [OFF_W-1:0]  offsetImm,
  input  logic [PC_W-1:0]   jumpTarget,
  input  logic              flagC,
  input  logic              flagZ,
  input  logic [REG_AW-1:0] linkReg,
  output logic [PC_W-1:0]   pcOut,
  output logic [PC_W-1:0]   linkValue,
  output logic              linkWrite
);

  pcStrobe_t strobes;

  pcs_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .advanceEn (advanceEn),
    .ctrlClass (ctrlClass),
    .condSel   (condSel),
    .flagC     (flagC),
    .flagZ     (flagZ),
    .linkReg   (linkReg),
    .strobes   (strobes)
  );

  pcs_datapath #(.PC_W(PC_W), .OFF_W(OFF_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .advanceEn  (advanceEn),
    .strobes    (strobes),
    .offsetImm  (offsetImm),
    .jumpTarget (jumpTarget),
    .pcOut      (pcOut),
    .linkValue  (linkValue)
  );

  assign linkWrite = strobes.writeLink;

  a_r9_link_value: assert property (@(posedge clk) disable iff (rst)
    linkWrite |-> (ctrlClass[1] && advanceEn));

endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advanceEn = 1'b0;
  logic [1:0]  ctrlClass = 2'b00;
  logic [1:0]  condSel = 2'b00;
  logic [9:0]  offsetImm = '0;
  logic [15:0] jumpTarget = '0;
  logic        flagC = 1'b0;
  logic        flagZ = 1'b0;
  logic [2:0]  linkReg = '0;
  logic [15:0] pcOut;
  logic [15:0] linkValue;
  logic        linkWrite;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [15:0] modelPc = '0;

  always #10 clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rst(rst), .advanceEn(advanceEn), .ctrlClass(ctrlClass),
    .condSel(condSel), .offsetImm(offsetImm), .jumpTarget(jumpTarget),
    .flagC(flagC), .flagZ(flagZ), .linkReg(linkReg),
    .pcOut(pcOut), .linkValue(linkValue), .linkWrite(linkWrite)
  );

  function automatic bit condTaken(input logic [1:0] cs, input logic c, input logic z);
    case (cs)
      2'b00: return z;
      2'b01: return !z;
      2'b10: return c;
      default: return !c;
    endcase
  endfunction

  function automatic logic [15:0] refNext(input logic [15:0] pc, input logic [1:0] cls,
      input logic [1:0] cs, input logic [9:0] off, input logic [15:0] tgt,
      input logic c, input logic z);
    logic [15:0] rel;
    rel = pc + 16'd1 + {{6{off[9]}}, off};
    case (cls)
      2'b00: return pc + 16'd1;
      2'b01: return condTaken(cs, c, z) ? rel : pc + 16'd1;
      2'b10: return rel;
      default: return tgt;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive on a falling edge, check combinational outputs, then the PC one edge later.
  task automatic step(input string tag, input logic [1:0] cls, input logic [1:0] cs,
      input logic [9:0] off, input logic [15:0] tgt, input logic c, input logic z,
      input logic [2:0] lr, input logic en);
    logic expLw;
    ctrlClass = cls; condSel = cs; offsetImm = off; jumpTarget = tgt;
    flagC = c; flagZ = z; linkReg = lr; advanceEn = en;
    #1;
    expLw = en && cls[1] && (lr != 3'd0);
    check({tag, " linkValue R9"}, linkValue, modelPc + 16'd1);
    check({tag, " linkWrite R9"}, {15'd0, linkWrite}, {15'd0, expLw});
    if (en) modelPc = refNext(modelPc, cls, cs, off, tgt, c, z);
    @(negedge clk);
    check({tag, " pc"}, pcOut, modelPc);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelPc = '0;
    check("R1 reset pc", pcOut, 16'h0000);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();
    step("R3 seq", 2'b00, 2'b00, 10'h3FF, 16'h1234, 1'b1, 1'b1, 3'd0, 1'b1);
    step("R3 seq2", 2'b00, 2'b11, 10'h000, 16'h0000, 1'b0, 1'b0, 3'd2, 1'b1);
    step("R2 hold jump", 2'b11, 2'b00, 10'h000, 16'hBEEF, 1'b0, 1'b0, 3'd5, 1'b0);
    step("R2 hold blink", 2'b10, 2'b00, 10'h010, 16'h0000, 1'b0, 1'b0, 3'd5, 1'b0);
    step("R4 beq taken", 2'b01, 2'b00, 10'd20, 16'h0, 1'b0, 1'b1, 3'd0, 1'b1);
    step("R5 beq not", 2'b01, 2'b00, 10'd20, 16'h0, 1'b1, 1'b0, 3'd0, 1'b1);
    step("R4 bne taken", 2'b01, 2'b01, 10'd7, 16'h0, 1'b1, 1'b0, 3'd0, 1'b1);
    step("R5 bne not", 2'b01, 2'b01, 10'd7, 16'h0, 1'b0, 1'b1, 3'd0, 1'b1);
    step("R4 bcs taken", 2'b01, 2'b10, 10'h3FD, 16'h0, 1'b1, 1'b0, 3'd0, 1'b1);
    step("R5 bcs not", 2'b01, 2'b10, 10'h3FD, 16'h0, 1'b0, 1'b1, 3'd0, 1'b1);
    step("R4 bcc taken", 2'b01, 2'b11, 10'd3, 16'h0, 1'b0, 1'b1, 3'd0, 1'b1);
    step("R5 bcc not", 2'b01, 2'b11, 10'd3, 16'h0, 1'b1, 1'b0, 3'd0, 1'b1);
    step("R8 jump mid", 2'b11, 2'b00, 10'h0, 16'h4000, 1'b0, 1'b0, 3'd0, 1'b1);
    step("R6 max fwd", 2'b01, 2'b00, 10'h1FF, 16'h0, 1'b0, 1'b1, 3'd0, 1'b1);
    step("R6 max back", 2'b01, 2'b00, 10'h200, 16'h0, 1'b0, 1'b1, 3'd0, 1'b1);
    step("R7 blink flags", 2'b10, 2'b00, 10'd40, 16'h0, 1'b0, 1'b0, 3'd3, 1'b1);
    step("R7 blink flags2", 2'b10, 2'b11, 10'h3F0, 16'h0, 1'b1, 1'b0, 3'd7, 1'b1);
    step("R10 blink r0", 2'b10, 2'b01, 10'd9, 16'h0, 1'b0, 1'b1, 3'd0, 1'b1);
    step("R10 jlink r0", 2'b11, 2'b00, 10'd0, 16'h2222, 1'b0, 1'b0, 3'd0, 1'b1);
    step("R8 jlink", 2'b11, 2'b00, 10'd0, 16'hFFFF, 1'b1, 1'b1, 3'd6, 1'b1);
    step("R11 seq wrap", 2'b00, 2'b00, 10'd0, 16'h0, 1'b0, 1'b0, 3'd0, 1'b1);
    step("R8 jump top", 2'b11, 2'b00, 10'd0, 16'hFFFE, 1'b0, 1'b0, 3'd1, 1'b1);
    step("R11 rel wrap", 2'b01, 2'b11, 10'd5, 16'h0, 1'b0, 1'b0, 3'd0, 1'b1);
    step("R11 back wrap", 2'b10, 2'b00, 10'h3F0, 16'h0, 1'b0, 1'b0, 3'd0, 1'b1);
    doReset();
    for (int i = 0; i < 400; i++) begin
      step("R4 random", 2'($urandom), 2'($urandom), 10'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom), 3'($urandom), ($urandom % 4) != 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule